// File: doc/BRIEF.md
# Battery Charger Mode Controller

This block decides the operating mode of a single-cell lithium charger. Comparator results arrive as digital flags: battery at or above the fast-charge level, battery at or above the float level, battery at or below the re-arm level (float minus the standby hysteresis), charge current at or below the termination level, supply headroom lost, and supply headroom low. An enable bit completes the inputs. Each comparator flag is sampled and then debounced. A flag must hold a new value for `DEB_CYCLES` consecutive clocks before the mode machine acts on it.

The outputs are a 3-bit mode code, a 2-bit current-select code for the analogue current source, and a `charging` status flag. Termination and re-arm thresholds are analogue settings that sit outside this block. The controller only acts on the flags they produce. An error caused by lost headroom clears by itself once headroom returns. A disable request overrides every other input on the next clock edge.

The asynchronous active-low reset is released synchronously through two internal flops.

Top module: `chg_mode_ctrl`

## Requirements
- R1: While reset is active and after it is released with `enable` low, `mode` is 0 (disabled), `isel` is 0 (off) and `charging` is 0.
- R2: When enabled, with no headroom error and the battery below the fast threshold, the mode becomes trickle (`mode`=1) with `isel`=1 (about one tenth of the fast current).
- R3: When enabled, with no headroom error and the battery at or above the fast threshold, trickle or disabled goes to fast (`mode`=2) with `isel`=2 (full current).
- R4: In fast mode with the debounced headroom-low flag set, `isel` is 3 (reduced current, 50 to 100 % of full); otherwise it is 2.
- R5: Fast mode moves to standby (`mode`=3, `isel`=0) when the float flag and the termination-current flag are both set.
- R6: Standby holds while the re-arm flag is clear, even if the battery falls below the float level. Once the re-arm flag is set, standby moves to fast (battery at or above the fast threshold) or to trickle.
- R7: With `enable` high and the debounced headroom-error flag set, the next mode is error (`mode`=4, `isel`=0), from any state.
- R8: When the headroom-error flag clears in error mode, the mode returns by itself to fast or trickle, with no reset.
- R9: A comparator flag whose new value lasts fewer than `DEB_CYCLES` clocks has no effect. A flag held steady changes `mode` exactly `DEB_CYCLES`+2 clock edges after the first edge that samples it.
- R10: With `enable` low, `mode` is 0 after the next clock edge, whatever the state and flags.
- R11: `charging` is 1 exactly when `isel` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Charger enable; low forces disabled mode |
| vbat_ge_fast | input | 1 | Battery at or above fast-charge threshold |
| vbat_ge_float | input | 1 | Battery at or above float threshold |
| vbat_le_rearm | input | 1 | Battery at or below float minus hysteresis |
| ichg_le_term | input | 1 | Charge current at or below termination level |
| headroom_err | input | 1 | Battery within about 50 mV of charger supply |
| headroom_low | input | 1 | Headroom small enough to need reduced current |
| mode | output | 3 | 0 disabled, 1 trickle, 2 fast, 3 standby, 4 error |
| isel | output | 2 | 0 off, 1 trickle, 2 full, 3 reduced |
| charging | output | 1 | Current source active |

## Verification
Every mode has its own code, so a wrong state register shows on `mode` and `isel` on the edge after it occurs. For example, a lost standby would appear as current turning back on before the re-arm flag rises. A miscounting debouncer shows up as a mode change one clock early or late relative to the DEB_CYCLES+2 latency, or as a short glitch getting through to `mode`. The bench therefore probes the exact edge where a change is due, and the edge just before it.

// File: rtl/chg_pkg.sv
package chg_pkg;

  typedef enum logic [2:0] {
    M_OFF     = 3'd0,
    M_TRICKLE = 3'd1,
    M_FAST    = 3'd2,
    M_STANDBY = 3'd3,
    M_ERROR   = 3'd4
  } chg_mode_e;

  typedef enum logic [1:0] {
    I_OFF     = 2'd0,
    I_TRICKLE = 2'd1,
    I_FULL    = 2'd2,
    I_REDUCED = 2'd3
  } chg_isel_e;

  // comparator flag positions inside the debounced flag vector
  localparam int NFLAG    = 6;
  localparam int FL_FAST  = 0;
  localparam int FL_FLOAT = 1;
  localparam int FL_TERM  = 2;
  localparam int FL_HERR  = 3;
  localparam int FL_HLOW  = 4;
  localparam int FL_REARM = 5;

endpackage

// File: rtl/chg_rst_sync.sv
module chg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage <= 2'b00;
    else        stage <= {stage[0], 1'b1};
  end

  assign rst_sync_n = stage[1];
endmodule

// File: rtl/chg_debounce.sv
module chg_debounce #(
  parameter int DEB_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic clean
);
  localparam int CW = (DEB_CYCLES < 2) ? 1 : $clog2(DEB_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(DEB_CYCLES - 1);

  logic          samp_q;
  logic          clean_q, clean_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  // counter advances only while the sample disagrees with the filtered value
  always_comb begin
    clean_d = clean_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b1;
    if (samp_q == clean_q) begin
      cnt_d = '0;
    end else if (cnt_q == LAST) begin
      clean_d = samp_q;
      cnt_d   = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q  <= 1'b0;
      clean_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      samp_q <= raw;
      if (cnt_en) begin
        clean_q <= clean_d;
        cnt_q   <= cnt_d;
      end
    end
  end

  assign clean = clean_q;
endmodule

// File: rtl/chg_mode_fsm.sv
module chg_mode_fsm
  import chg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [NFLAG-1:0] flg,
  output chg_mode_e        state
);
  chg_mode_e st_q, st_d;
  logic      fast, flt, term, herr, rearm;

  assign fast  = flg[FL_FAST];
  assign flt   = flg[FL_FLOAT];
  assign term  = flg[FL_TERM];
  assign herr  = flg[FL_HERR];
  assign rearm = flg[FL_REARM];

  always_comb begin
    st_d = st_q;
    if (!enable) begin
      st_d = M_OFF;
    end else if (herr) begin
      st_d = M_ERROR;
    end else begin
      unique case (st_q)
        M_OFF, M_ERROR: st_d = fast ? M_FAST : M_TRICKLE;
        M_TRICKLE:      if (fast) st_d = M_FAST;
        M_FAST: begin
          if (!fast)            st_d = M_TRICKLE;
          else if (flt && term) st_d = M_STANDBY;
        end
        M_STANDBY:      if (rearm) st_d = fast ? M_FAST : M_TRICKLE;
        default:        st_d = M_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= M_OFF;
    else        st_q <= st_d;
  end

  assign state = st_q;
endmodule

// File: rtl/chg_isel_map.sv
module chg_isel_map
  import chg_pkg::*;
(
  input  chg_mode_e state,
  input  logic      hlow,
  output chg_isel_e isel,
  output logic      active
);
  always_comb begin
    unique case (state)
      M_TRICKLE: isel = I_TRICKLE;
      M_FAST:    isel = hlow ? I_REDUCED : I_FULL;
      default:   isel = I_OFF;
    endcase
    active = (state == M_TRICKLE) || (state == M_FAST);
  end
endmodule

// File: rtl/chg_mode_ctrl.sv
module chg_mode_ctrl
  import chg_pkg::*;
#(
  parameter int DEB_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       vbat_ge_fast,
  input  logic       vbat_ge_float,
  input  logic       vbat_le_rearm,
  input  logic       ichg_le_term,
  input  logic       headroom_err,
  input  logic       headroom_low,
  output logic [2:0] mode,
  output logic [1:0] isel,
  output logic       charging
);
  logic             rst_i_n;
  logic [NFLAG-1:0] flg_raw;
  logic [NFLAG-1:0] flg_db;
  chg_mode_e        state;
  chg_isel_e        isel_e;

  chg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  always_comb begin
    flg_raw           = '0;
    flg_raw[FL_FAST]  = vbat_ge_fast;
    flg_raw[FL_FLOAT] = vbat_ge_float;
    flg_raw[FL_TERM]  = ichg_le_term;
    flg_raw[FL_HERR]  = headroom_err;
    flg_raw[FL_HLOW]  = headroom_low;
    flg_raw[FL_REARM] = vbat_le_rearm;
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_deb
    chg_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
      .clk   (clk),
      .rst_n (rst_i_n),
      .raw   (flg_raw[g]),
      .clean (flg_db[g])
    );
  end

  chg_mode_fsm u_fsm (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .enable (enable),
    .flg    (flg_db),
    .state  (state)
  );

  chg_isel_map u_map (
    .state  (state),
    .hlow   (flg_db[FL_HLOW]),
    .isel   (isel_e),
    .active (charging)
  );

  assign mode = state;
  assign isel = isel_e;
endmodule

// File: rtl/chg_mode_ctrl_sva.sv
module chg_mode_ctrl_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic [2:0] mode,
  input logic [1:0] isel,
  input logic       charging,
  input logic       herr_db,
  input logic       rearm_db
);
  assert_disable_forces_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> mode == 3'd0);

  assert_herr_to_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && herr_db) |=> mode == 3'd4);

  assert_error_recovers_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4 && enable && !herr_db) |=> (mode == 3'd1 || mode == 3'd2));

  assert_standby_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 && enable && !herr_db && !rearm_db) |=> mode == 3'd3);

  assert_idle_no_current_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 || mode == 3'd3 || mode == 3'd4) |-> (isel == 2'd0 && !charging));

  assert_legal_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mode <= 3'd4);

  assert_flag_matches_isel_R11: assert property (@(posedge clk) disable iff (!rst_n)
    charging == (isel != 2'd0));
endmodule

bind chg_mode_ctrl chg_mode_ctrl_sva u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .enable   (enable),
  .mode     (mode),
  .isel     (isel),
  .charging (charging),
  .herr_db  (flg_db[3]),
  .rearm_db (flg_db[5])
);

// File: tb/chg_mode_ctrl_test.sv
module chg_mode_ctrl_test;
  localparam int DEB = 4;

  logic       clk, rst_n;
  logic       enable, v_fast, v_float, v_rearm, i_term, h_err, h_low;
  logic [2:0] mode;
  logic [1:0] isel;
  logic       charging;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  chg_mode_ctrl #(.DEB_CYCLES(DEB)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .vbat_ge_fast(v_fast), .vbat_ge_float(v_float), .vbat_le_rearm(v_rearm),
    .ichg_le_term(i_term), .headroom_err(h_err), .headroom_low(h_low),
    .mode(mode), .isel(isel), .charging(charging)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {enable, fast, float, term, herr, hlow, rearm, exp_mode[2:0], exp_isel[1:0]}
  localparam int NV = 12;
  localparam logic [11:0] VEC [NV] = '{
    {7'b1000000, 3'd1, 2'd1},  // trickle below fast threshold
    {7'b1100000, 3'd2, 2'd2},  // fast
    {7'b1100010, 3'd2, 2'd3},  // reduced current on low headroom
    {7'b1110000, 3'd2, 2'd2},  // float reached, current still high
    {7'b1111000, 3'd3, 2'd0},  // termination -> standby
    {7'b1101000, 3'd3, 2'd0},  // below float, no re-arm: hold
    {7'b1100001, 3'd2, 2'd0 + 2'd2},  // re-arm -> fast
    {7'b1100100, 3'd4, 2'd0},  // headroom error
    {7'b1100000, 3'd2, 2'd2},  // auto recovery to fast
    {7'b1000000, 3'd1, 2'd1},  // drop to trickle
    {7'b1000100, 3'd4, 2'd0},  // error from trickle
    {7'b1000000, 3'd1, 2'd1}   // auto recovery to trickle
  };

  function automatic string vtag(int i);
    case (i)
      0, 9:  return "R2";
      1:     return "R3";
      2:     return "R4";
      3, 4:  return "R5";
      5, 6:  return "R6";
      7, 10: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string req, logic [2:0] em, logic [1:0] ei);
    logic ec;
    ec = (ei != 2'd0);  // R11: charging follows isel
    n_run++;
    if (mode !== em || isel !== ei || charging !== ec) begin
      n_fail++;
      $display("FAIL %s: mode=%0d isel=%0d charging=%0d expected mode=%0d isel=%0d charging=%0d",
               req, mode, isel, charging, em, ei, ec);
    end
  endtask

  task automatic drive(logic [6:0] v);
    {enable, v_fast, v_float, i_term, h_err, h_low, v_rearm} = v;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0;
    drive(7'b0);
    repeat (3) @(negedge clk);
    check("R1", 3'd0, 2'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", 3'd0, 2'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][11:5]);
      repeat (10) @(negedge clk);
      check(vtag(i), VEC[i][4:2], VEC[i][1:0]);
    end

    // R9: glitch shorter than DEB cycles is ignored (state is trickle)
    v_fast = 1'b1;
    repeat (DEB - 1) @(negedge clk);
    v_fast = 1'b0;
    repeat (10) @(negedge clk);
    check("R9", 3'd1, 2'd1);

    // R9: steady flag moves mode exactly DEB+2 edges after drive
    v_fast = 1'b1;
    repeat (DEB + 1) @(negedge clk);
    check("R9", 3'd1, 2'd1);
    @(negedge clk);
    check("R9", 3'd2, 2'd2);

    // R10: disable forces off on the next edge
    enable = 1'b0;
    @(negedge clk);
    check("R10", 3'd0, 2'd0);

    // R7: headroom error while disabled, then enable goes straight to error
    h_err = 1'b1;
    repeat (10) @(negedge clk);
    check("R10", 3'd0, 2'd0);
    enable = 1'b1;
    @(negedge clk);
    check("R7", 3'd4, 2'd0);

    // R8: recovery once headroom returns
    h_err = 1'b0;
    repeat (10) @(negedge clk);
    check("R8", 3'd2, 2'd2);

    // R10: disable during standby
    v_float = 1'b1; i_term = 1'b1;
    repeat (10) @(negedge clk);
    check("R5", 3'd3, 2'd0);
    enable = 1'b0;
    @(negedge clk);
    check("R10", 3'd0, 2'd0);

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end
endmodule